// File: doc/BRIEF.md
# Message Channel Reply Watchdog

This block guards the sending side of a handshaked, byte-serial message channel that travels one byte slot per frame on a time-division control link. After the sender puts a byte on the link, it waits for the far device to acknowledge it. The block times that wait. If the acknowledge does not arrive within 5 ms, the block aborts the message. It forces the end-of-message line (MX) high for two whole frames and raises a sticky abort flag.

The timer counts pulses of a 1 µs timebase input. A configuration bit turns the whole function on or off. While the abort runs, the block reports busy so that the sender drops back to idle. Once the forced frames end, the sender's own MX output reaches the link again.

Top module: `mon_reply_watchdog`

## Requirements
- R1: After reset the block is idle with the timer at zero. `abortFlag` and `abortBusy` are 0, and `mxOut` equals `txMx`.
- R2: The timer runs only while `cfgTimeoutEn`=1, `txWaiting`=1 and `rxAck`=0. It counts `usTick` pulses, starting from zero at the beginning of each wait.
- R3: Expiry happens on the 5000th counted tick and not on the 4999th. In the cycle after that tick, `abortFlag` and `abortBusy` read 1.
- R4: A cycle with `rxAck`=1 clears and stops the timer. The next wait needs a full 5000 new ticks before it expires.
- R5: With `cfgTimeoutEn`=0, an active wait is cancelled at once. No abort follows, however many ticks arrive.
- R6: If `rxAck`=1 arrives in the same cycle as the 5000th tick, the acknowledge wins and no abort is raised.
- R7: After expiry, `mxOut` keeps following `txMx` until the next `frameStrobe`. From the cycle after that strobe, `mxOut` is held at 1 whatever `txMx` is. It is released in the cycle after the second strobe that follows, so the override lasts exactly two frames.
- R8: `abortBusy` stays 1 from expiry until the override is released. During that time `txWaiting` and `usTick` start no new timer. Afterwards the block is idle.
- R9: `abortFlag` stays 1 until a cycle with `flagClr`=1. If a flag set and `flagClr` fall in the same cycle, the flag ends at 1.
- R10: When no abort is pending or running, `frameStrobe` has no effect and `mxOut` equals `txMx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTimeoutEn | input | 1 | Timeout function enable (configuration bit) |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| usTick | input | 1 | One-cycle pulse every 1 µs |
| txWaiting | input | 1 | Sender is waiting for the far-end acknowledge |
| rxAck | input | 1 | Acknowledge from the far end seen this cycle |
| txMx | input | 1 | Sender's normal MX value |
| flagClr | input | 1 | Write-one-to-clear pulse for the abort flag |
| mxOut | output | 1 | MX toward the link, forced high during an abort |
| abortFlag | output | 1 | Sticky abort status flag |
| abortBusy | output | 1 | Abort pending or in progress; sender must go idle |

## Verification
The acknowledge and the expiring 5000th tick can land in the same cycle. The bench drives exactly 4999 ticks, then raises `rxAck` together with the next tick. It then confirms that neither the flag nor busy rises, and that a new wait needs a full 5000 ticks again. The flag's set and its write-one-to-clear can also coincide. The bench places `flagClr` on the cycle of the expiring tick and expects the flag to read 1 afterwards. Only a separate later clear pulse may bring the flag back to 0.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PEND  = 2'd2,
    ST_ABORT = 2'd3
  } mrw_state_e;

  // strobes from the sequencer to the counters
  typedef struct packed {
    logic tmrClr;
    logic tmrInc;
    logic frmClr;
    logic frmInc;
    logic flagSet;
  } mrw_strobes_t;

endpackage

// File: rtl/mrw_datapath.sv
module mrw_datapath
  import mrw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 5000,
  parameter int ABORT_FRAMES  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  mrw_strobes_t stb,
  input  logic         flagClr,
  output logic         tmrLast,
  output logic         frmLast,
  output logic         abortFlag
);

  localparam int TMR_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam int FRM_W = (ABORT_FRAMES > 2) ? $clog2(ABORT_FRAMES) : 1;

  logic [TMR_W-1:0] tmrCount;
  logic [FRM_W-1:0] frmCount;

  // reply timer: counts ticks while the sequencer allows
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCount <= '0;
    end else if (stb.tmrClr) begin
      tmrCount <= '0;
    end else if (stb.tmrInc) begin
      tmrCount <= tmrCount + 1'b1;
    end
  end

  assign tmrLast = (tmrCount == TMR_W'(TIMEOUT_TICKS - 1));

  // frames already spent with MX forced high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmCount <= '0;
    end else if (stb.frmClr) begin
      frmCount <= '0;
    end else if (stb.frmInc) begin
      frmCount <= frmCount + 1'b1;
    end
  end

  generate
    if (ABORT_FRAMES <= 1) begin : g_singleFrame
      assign frmLast = 1'b1;
    end else begin : g_multiFrame
      assign frmLast = (frmCount == FRM_W'(ABORT_FRAMES - 1));
    end
  endgenerate

  // sticky flag, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortFlag <= 1'b0;
    end else if (stb.flagSet) begin
      abortFlag <= 1'b1;
    end else if (flagClr) begin
      abortFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/mrw_ctrl.sv
module mrw_ctrl
  import mrw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgTimeoutEn,
  input  logic         frameStrobe,
  input  logic         usTick,
  input  logic         txWaiting,
  input  logic         rxAck,
  input  logic         tmrLast,
  input  logic         frmLast,
  output mrw_strobes_t stb,
  output mrw_state_e   state,
  output logic         mxForce,
  output logic         busy
);

  mrw_state_e stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        stb.tmrClr = 1'b1;
        stb.frmClr = 1'b1;
        if (cfgTimeoutEn && txWaiting && !rxAck) begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!cfgTimeoutEn || rxAck || !txWaiting) begin
          stb.tmrClr = 1'b1;
          stateNext  = ST_IDLE;
        end else if (usTick) begin
          if (tmrLast) begin
            stb.tmrClr  = 1'b1;
            stb.flagSet = 1'b1;
            stateNext   = ST_PEND;
          end else begin
            stb.tmrInc = 1'b1;
          end
        end
      end
      ST_PEND: begin
        if (frameStrobe) begin
          stb.frmClr = 1'b1;
          stateNext  = ST_ABORT;
        end
      end
      ST_ABORT: begin
        if (frameStrobe) begin
          if (frmLast) begin
            stateNext = ST_IDLE;
          end else begin
            stb.frmInc = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign mxForce = (state == ST_ABORT);
  assign busy    = (state == ST_PEND) || (state == ST_ABORT);

endmodule

// File: rtl/mon_reply_watchdog.sv
module mon_reply_watchdog
  import mrw_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 5000,
  parameter int ABORT_FRAMES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgTimeoutEn,
  input  logic frameStrobe,
  input  logic usTick,
  input  logic txWaiting,
  input  logic rxAck,
  input  logic txMx,
  input  logic flagClr,
  output logic mxOut,
  output logic abortFlag,
  output logic abortBusy
);

  mrw_strobes_t ctrlStb;
  mrw_state_e   ctrlState;
  logic         tmrLast;
  logic         frmLast;
  logic         mxForce;

  mrw_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgTimeoutEn (cfgTimeoutEn),
    .frameStrobe  (frameStrobe),
    .usTick       (usTick),
    .txWaiting    (txWaiting),
    .rxAck        (rxAck),
    .tmrLast      (tmrLast),
    .frmLast      (frmLast),
    .stb          (ctrlStb),
    .state        (ctrlState),
    .mxForce      (mxForce),
    .busy         (abortBusy)
  );

  mrw_datapath #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .ABORT_FRAMES  (ABORT_FRAMES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctrlStb),
    .flagClr   (flagClr),
    .tmrLast   (tmrLast),
    .frmLast   (frmLast),
    .abortFlag (abortFlag)
  );

  // override takes priority over the sender's MX
  assign mxOut = mxForce | txMx;

endmodule

// File: rtl/mrw_checker.sv
module mrw_checker
  import mrw_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cfgTimeoutEn,
  input logic       frameStrobe,
  input logic       rxAck,
  input logic       txMx,
  input logic       flagClr,
  input logic       mxOut,
  input logic       abortFlag,
  input logic       abortBusy,
  input mrw_state_e ctrlState
);

  // R7
  mx_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_ABORT) |-> mxOut);

  // R7
  release_on_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(abortBusy) |-> $past(frameStrobe));

  // R3
  flag_on_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortFlag) |-> (ctrlState == ST_PEND));

  // R5
  no_abort_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgTimeoutEn |=> !$rose(abortFlag));

  // R6
  ack_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxAck |=> !$rose(abortFlag));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !flagClr) |=> abortFlag);

  // R10
  mx_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !abortBusy |-> (mxOut == txMx));

endmodule

bind mon_reply_watchdog mrw_checker u_mrw_checker (
  .clk          (clk),
  .rstN         (rstN),
  .cfgTimeoutEn (cfgTimeoutEn),
  .frameStrobe  (frameStrobe),
  .rxAck        (rxAck),
  .txMx         (txMx),
  .flagClr      (flagClr),
  .mxOut        (mxOut),
  .abortFlag    (abortFlag),
  .abortBusy    (abortBusy),
  .ctrlState    (ctrlState)
);

// File: tb/mon_reply_watchdog_tb.sv
module mon_reply_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 5000;

  logic clk = 1'b0;
  logic rstN, cfgTimeoutEn, frameStrobe, usTick, txWaiting, rxAck, txMx, flagClr;
  logic mxOut, abortFlag, abortBusy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mon_reply_watchdog u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .cfgTimeoutEn (cfgTimeoutEn),
    .frameStrobe  (frameStrobe),
    .usTick       (usTick),
    .txWaiting    (txWaiting),
    .rxAck        (rxAck),
    .txMx         (txMx),
    .flagClr      (flagClr),
    .mxOut        (mxOut),
    .abortFlag    (abortFlag),
    .abortBusy    (abortBusy)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runTicks(int n);
    usTick = 1'b1;
    cyc(n);
    usTick = 1'b0;
  endtask

  task automatic startWait();
    txWaiting = 1'b1;
    cyc(1);
  endtask

  task automatic strobeFrame();
    frameStrobe = 1'b1;
    cyc(1);
    frameStrobe = 1'b0;
  endtask

  task automatic finishAbort();
    txWaiting = 1'b0;
    strobeFrame();
    cyc(3);
    strobeFrame();
    cyc(3);
    strobeFrame();
    chk("R8 idle after abort", abortBusy, 1'b0);
  endtask

  task automatic testReset();
    txMx = 1'b1;
    cyc(1);
    chk("R1 flag clear", abortFlag, 1'b0);
    chk("R1 busy clear", abortBusy, 1'b0);
    chk("R1 mx follows high", mxOut, 1'b1);
    txMx = 1'b0;
    cyc(1);
    chk("R1 mx follows low", mxOut, 1'b0);
  endtask

  task automatic testIdleFrames();
    txMx = 1'b1;
    strobeFrame();
    chk("R10 mx after strobe high", mxOut, 1'b1);
    txMx = 1'b0;
    strobeFrame();
    chk("R10 mx after strobe low", mxOut, 1'b0);
  endtask

  task automatic testExpiry();
    startWait();
    runTicks(TICKS - 1);
    cyc(1);
    chk("R3 no expiry at 4999", abortFlag, 1'b0);
    chk("R2 counting stays quiet", abortBusy, 1'b0);
    runTicks(1);
    chk("R3 flag at 5000", abortFlag, 1'b1);
    chk("R3 busy at 5000", abortBusy, 1'b1);
    txMx = 1'b0;
    runTicks(50);
    chk("R7 pending follows txMx", mxOut, 1'b0);
    chk("R8 ticks ignored while busy", abortBusy, 1'b1);
    strobeFrame();
    chk("R7 forced first frame", mxOut, 1'b1);
    cyc(4);
    chk("R7 forced mid frame one", mxOut, 1'b1);
    strobeFrame();
    chk("R7 forced second frame", mxOut, 1'b1);
    cyc(4);
    chk("R7 forced mid frame two", mxOut, 1'b1);
    txWaiting = 1'b0;
    strobeFrame();
    chk("R7 released after two frames", mxOut, 1'b0);
    chk("R8 busy released", abortBusy, 1'b0);
    chk("R9 flag sticky", abortFlag, 1'b1);
    flagClr = 1'b1;
    cyc(1);
    flagClr = 1'b0;
    chk("R9 flag cleared", abortFlag, 1'b0);
  endtask

  task automatic testAckRace();
    startWait();
    runTicks(TICKS - 1);
    usTick = 1'b1;
    rxAck  = 1'b1;
    cyc(1);
    usTick = 1'b0;
    rxAck  = 1'b0;
    chk("R6 ack wins flag", abortFlag, 1'b0);
    chk("R6 ack wins busy", abortBusy, 1'b0);
    cyc(1);
    runTicks(TICKS - 1);
    chk("R4 restart from zero", abortFlag, 1'b0);
    runTicks(1);
    chk("R4 expires after full wait", abortFlag, 1'b1);
    finishAbort();
    flagClr = 1'b1;
    cyc(1);
    flagClr = 1'b0;
  endtask

  task automatic testDisable();
    startWait();
    runTicks(3000);
    cfgTimeoutEn = 1'b0;
    runTicks(6000);
    chk("R5 disabled no abort", abortFlag, 1'b0);
    chk("R5 disabled not busy", abortBusy, 1'b0);
    cfgTimeoutEn = 1'b1;
    cyc(1);
    runTicks(TICKS - 1);
    chk("R5 cancelled timer restarts", abortFlag, 1'b0);
    txWaiting = 1'b0;
    cyc(2);
  endtask

  task automatic testFlagRace();
    startWait();
    runTicks(TICKS - 1);
    usTick  = 1'b1;
    flagClr = 1'b1;
    cyc(1);
    usTick  = 1'b0;
    flagClr = 1'b0;
    chk("R9 set beats clear", abortFlag, 1'b1);
    finishAbort();
    chk("R9 still set", abortFlag, 1'b1);
    flagClr = 1'b1;
    cyc(1);
    flagClr = 1'b0;
    chk("R9 later clear", abortFlag, 1'b0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rstN = 1'b0;
    cfgTimeoutEn = 1'b1;
    frameStrobe = 1'b0;
    usTick = 1'b0;
    txWaiting = 1'b0;
    rxAck = 1'b0;
    txMx = 1'b0;
    flagClr = 1'b0;
    cyc(3);
    rstN = 1'b1;
    testReset();
    testIdleFrames();
    testExpiry();
    testAckRace();
    testDisable();
    testFlagRace();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

endmodule